// File: doc/BRIEF.md
# DMA Request Edge-Sense Acceptance Controller

This block sits between an external active-low DMA request pin and the transfer sequencer of a single-channel DMA engine that runs single-address transfers. Once the channel has been enabled, it samples the pin on every rising clock edge. A low level seen while acceptance is open is latched as a held request. The held request is released when the current bus cycle ends. At that moment the block issues a one-clock start pulse to the sequencer.

After a start, the block stops looking for low levels and looks for the pin to return high. It opens acceptance again only after a high level has been seen and the DMA single cycle has finished. The result is falling-edge triggering that is tied to the progress of the transfer: a pin held low cannot start a second transfer. Clearing the enable bit or signalling the end of the whole transfer sends the block back to idle. Any held request is dropped at that point.

Top module: `dmareq_edge_accept`

## Requirements
- R1: A synchronous active-high reset leaves the block idle with no held request, and `startPulse` low. Pin activity after reset starts nothing until the block is enabled.
- R2: Sampling starts only on the first rising edge after a clock edge at which `enWrEnd` is high with `xferEn` high and `xferDone` low. A low pin before that point is ignored.
- R3: While acceptance is open, a low `reqN` at a rising edge latches a held request. `startPulse` is high for exactly one clock, in the cycle that follows the first later edge with `busCycEnd` high.
- R4: A held request stays until `busCycEnd` is seen, even if the pin returns high. It yields exactly one start pulse.
- R5: Between a start and the edge at which `singleDone` is high, low pin levels are ignored. If `reqN` was sampled high at any edge from the one after the start up to and including the `singleDone` edge, acceptance reopens right after that edge.
- R6: If no high level was sampled by the `singleDone` edge, acceptance stays closed while the pin stays low. It reopens on the clock after the first high sample, so a pin stuck low gives no second start.
- R7: Two start pulses are always separated by at least two clocks with `startPulse` low, so accept-to-reaccept spans at least 3 clocks.
- R8: `xferEn` low or `xferDone` high at an edge returns the block to idle and discards a held request. No start follows until a new enable write.
- R9: The accept, hold, release, high-sample and reopen sequence repeats for each request while the channel stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; sampling on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqN | input | 1 | External DMA request pin, active low |
| enWrEnd | input | 1 | End of the write cycle to the enable register |
| xferEn | input | 1 | Channel transfer-enable bit |
| busCycEnd | input | 1 | End of the current bus cycle |
| singleDone | input | 1 | Current DMA single cycle has completed |
| xferDone | input | 1 | Whole transfer has completed |
| startPulse | output | 1 | One-clock activation strobe to the transfer sequencer |

## Verification
The pin is driven with several patterns:
- a clean low-then-high request that returns high before the single cycle ends;
- a pin that rises only on the same edge as `singleDone`;
- a pin held low across the end of the single cycle;
- low levels that arrive during the transfer's own cycle or before enabling.

These patterns tell real edge re-arming apart from plain level triggering. They also show that a late high sample still counts, and that requests outside the open window are ignored. Back-to-back requests at the tightest legal timing probe the minimum spacing. Aborts while a request is held show that the request is dropped rather than delayed.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_HELD,
    ST_REARM,
    ST_STUCK
  } accState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic trackHigh;  // record a high pin sample
    logic clrHigh;    // forget earlier high samples
    logic fire;       // launch the start pulse
  } accStrobe_t;

endpackage

// File: rtl/dmareq_accept_dp.sv
module dmareq_accept_dp
  import dmareq_pkg::*;
#(
  parameter bit REQ_ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqPin,
  input  accStrobe_t strobe,
  output logic       pinAsserted,
  output logic       highSeen,
  output logic       startPulse
);

  generate
    if (REQ_ACTIVE_LOW) begin : g_low
      assign pinAsserted = ~reqPin;
    end else begin : g_high
      assign pinAsserted = reqPin;
    end
  endgenerate

  // Remembers that the pin was seen released since the last start
  always_ff @(posedge clk) begin
    if (rst) begin
      highSeen <= 1'b0;
    end else if (strobe.clrHigh) begin
      highSeen <= 1'b0;
    end else if (strobe.trackHigh && !pinAsserted) begin
      highSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startPulse <= 1'b0;
    end else begin
      startPulse <= strobe.fire;
    end
  end

endmodule

// File: rtl/dmareq_accept_ctrl.sv
module dmareq_accept_ctrl
  import dmareq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enWrEnd,
  input  logic       xferEn,
  input  logic       xferDone,
  input  logic       busCycEnd,
  input  logic       singleDone,
  input  logic       pinAsserted,
  input  logic       highSeen,
  output accStrobe_t strobe
);

  accState_t state, stateNext;
  logic abortNow;

  assign abortNow = !xferEn || xferDone;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (state != ST_IDLE && abortNow) begin
      stateNext      = ST_IDLE;
      strobe.clrHigh = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enWrEnd && !abortNow) stateNext = ST_OPEN;
        end
        ST_OPEN: begin
          if (pinAsserted) stateNext = ST_HELD;
        end
        ST_HELD: begin
          // held request released at end of bus cycle
          if (busCycEnd) begin
            stateNext      = ST_REARM;
            strobe.fire    = 1'b1;
            strobe.clrHigh = 1'b1;
          end
        end
        ST_REARM: begin
          strobe.trackHigh = 1'b1;
          if (singleDone) begin
            stateNext = (highSeen || !pinAsserted) ? ST_OPEN : ST_STUCK;
          end
        end
        ST_STUCK: begin
          if (!pinAsserted) stateNext = ST_OPEN;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/dmareq_edge_accept.sv
module dmareq_edge_accept
  import dmareq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reqN,
  input  logic enWrEnd,
  input  logic xferEn,
  input  logic busCycEnd,
  input  logic singleDone,
  input  logic xferDone,
  output logic startPulse
);

  accStrobe_t strobe;
  logic pinAsserted;
  logic highSeen;

  dmareq_accept_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enWrEnd    (enWrEnd),
    .xferEn     (xferEn),
    .xferDone   (xferDone),
    .busCycEnd  (busCycEnd),
    .singleDone (singleDone),
    .pinAsserted(pinAsserted),
    .highSeen   (highSeen),
    .strobe     (strobe)
  );

  dmareq_accept_dp #(.REQ_ACTIVE_LOW(1'b1)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .reqPin     (reqN),
    .strobe     (strobe),
    .pinAsserted(pinAsserted),
    .highSeen   (highSeen),
    .startPulse (startPulse)
  );

endmodule

// File: rtl/dmareq_accept_chk.sv
module dmareq_accept_chk (
  input logic clk,
  input logic rst,
  input logic reqN,
  input logic xferEn,
  input logic xferDone,
  input logic startPulse
);

  // Pin released since previous start (or since disable)
  logic hiArm;
  always_ff @(posedge clk) begin
    if (rst)                             hiArm <= 1'b1;
    else if (startPulse)                 hiArm <= reqN;
    else if (!xferEn || xferDone || reqN) hiArm <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !startPulse); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse); // R3

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse ##1 !startPulse); // R7

  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!xferEn || xferDone) |=> !startPulse); // R8

  AST_EDGE_REARM: assert property (@(posedge clk) disable iff (rst)
    $rose(startPulse) |-> hiArm); // R6

endmodule

bind dmareq_edge_accept dmareq_accept_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqN      (reqN),
  .xferEn    (xferEn),
  .xferDone  (xferDone),
  .startPulse(startPulse)
);

// File: tb/tb_dmareq_edge_accept.sv
`timescale 1ns/1ps
module tb_dmareq_edge_accept;

  logic clk = 1'b0;
  logic rst, reqN, enWrEnd, xferEn, busCycEnd, singleDone, xferDone;
  logic startPulse;
  int   nChecks = 0;
  int   nFails  = 0;

  always #2 clk = ~clk;

  dmareq_edge_accept dut (
    .clk(clk), .rst(rst), .reqN(reqN), .enWrEnd(enWrEnd), .xferEn(xferEn),
    .busCycEnd(busCycEnd), .singleDone(singleDone), .xferDone(xferDone),
    .startPulse(startPulse)
  );

  // {reqN, enWrEnd, xferEn, busCycEnd, singleDone, xferDone, expPulse}
  localparam int NV = 20;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_1_1_0_0_0_0, // enable write, open next
    7'b0_0_1_0_0_0_0, // low sampled, held
    7'b1_0_1_0_0_0_0, // pin back high, still held (R4)
    7'b1_0_1_1_0_0_1, // bus end -> start (R3)
    7'b1_0_1_0_0_0_0, // high seen
    7'b1_0_1_0_1_0_0, // single done -> open (R5)
    7'b0_0_1_0_0_0_0, // held
    7'b0_0_1_1_0_0_1, // start, pin low (R9)
    7'b0_0_1_0_1_0_0, // single done, still low -> stuck (R6)
    7'b0_0_1_1_0_0_0, // stuck, no start (R6)
    7'b1_0_1_0_0_0_0, // high -> open
    7'b0_0_1_0_0_0_0, // held
    7'b1_0_1_1_0_0_1, // start
    7'b1_0_1_0_1_0_0, // high on done edge -> open (R5)
    7'b0_0_1_0_0_0_0, // held
    7'b0_0_1_1_0_0_1, // start, 3 clocks after previous (R7)
    7'b0_0_1_1_0_0_0, // low during single ignored (R5)
    7'b0_0_1_0_0_1_0, // transfer done -> idle (R8)
    7'b0_0_1_1_0_0_0, // idle: nothing (R8)
    7'b1_0_1_1_1_0_0
  };

  task automatic drive(input logic r, w, e, b, s, d);
    @(negedge clk);
    reqN = r; enWrEnd = w; xferEn = e; busCycEnd = b; singleDone = s; xferDone = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic exp, input string tag);
    nChecks++;
    if (startPulse !== exp) begin
      nFails++;
      $display("FAIL %s: startPulse=%0b expected=%0b at %0t", tag, startPulse, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; reqN = 1'b1; enWrEnd = 1'b0; xferEn = 1'b0;
    busCycEnd = 1'b0; singleDone = 1'b0; xferDone = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 reset");
    @(negedge clk); rst = 1'b0;

    // R1 / R2: low pin with enable bit but no enable write
    drive(0, 0, 1, 0, 0, 0); check(1'b0, "R2 before enable");
    drive(0, 0, 1, 1, 0, 0); check(1'b0, "R1 no start after reset");
    drive(1, 0, 1, 1, 0, 0); check(1'b0, "R2 before enable");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check(VEC[i][0], $sformatf("R3/R5/R6/R7/R9 vector %0d", i));
    end

    // R4: held request waits long, gives exactly one start
    drive(1, 1, 1, 0, 0, 0); check(1'b0, "R4 open");
    drive(0, 0, 1, 0, 0, 0); check(1'b0, "R4 held");
    for (int k = 0; k < 6; k++) begin
      drive(k[0], 0, 1, 0, 0, 0); check(1'b0, "R4 waiting");
    end
    drive(1, 0, 1, 1, 0, 0); check(1'b1, "R4 release");
    drive(1, 0, 1, 1, 0, 0); check(1'b0, "R4 only one start");
    drive(1, 0, 1, 0, 1, 0); check(1'b0, "R4 reopen");

    // R8: abort by enable clear discards held request
    drive(0, 0, 1, 0, 0, 0); check(1'b0, "R8 held");
    drive(0, 0, 0, 0, 0, 0); check(1'b0, "R8 disable");
    drive(0, 0, 1, 1, 0, 0); check(1'b0, "R8 held request dropped");
    drive(0, 0, 1, 1, 0, 0); check(1'b0, "R8 still idle");
    // R2: new enable write with pin already low accepts
    drive(0, 1, 1, 0, 0, 0); check(1'b0, "R2 enable write");
    drive(0, 0, 1, 0, 0, 0); check(1'b0, "R2 sampled low");
    drive(1, 0, 1, 1, 0, 0); check(1'b1, "R2 start after enable");

    // R9: repeated requests at the tightest timing
    drive(1, 0, 1, 0, 1, 0); check(1'b0, "R9 reopen");
    for (int n = 0; n < 5; n++) begin
      drive(0, 0, 1, 0, 0, 0); check(1'b0, "R9 held");
      drive(1, 0, 1, 1, 0, 0); check(1'b1, "R9 start");
      drive(1, 0, 1, 0, 1, 0); check(1'b0, "R9 reopen");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule